// File: doc/BRIEF.md
# Multiprocessor Interrupt Routing Controller

This block steers interrupts to up to four CPUs from behind a plain 64-bit register bus. It holds one 64-bit device mask per CPU. It samples a shared 64-bit raw device request input on every clock and keeps, per CPU, a masked request equal to that CPU's mask ANDed with the raw requests. A CPU's device interrupt line is high while its masked request is nonzero. The line follows a mask write or a change on the raw input one clock later.

The block also keeps two pending vectors with one bit per CPU. The inter-processor interrupt (IPI) vector is set and cleared by software. The interval-timer vector is set for every CPU by a tick input and cleared by software. Set and clear fields are packed into one miscellaneous register, and dedicated registers do the same work by CPU bitmask. A request that has nothing to do, such as posting an IPI that is already pending or clearing a bit that is not pending, changes no state and sets a sticky error flag.

The register index is the byte address shifted right by 6. The register selector is an enumerated decode with the values ZERO, MISC, MASK, MREQ, IPI_PEND, TMR_PEND and IPI_POST. The pending vectors move between "clear" and "pending" per CPU on the transitions post, clear and tick.

Top module: `irq_route_ctrl`

## Requirements
- R1: The register index is bus_addr >> 6. The low six address bits never change which register is reached.
- R2: Indices 6 to 9 hold the masks of CPU 0 to 3 and read back the value written. Indices 10 to 13 are read-only and return mask AND raw request for CPU 0 to 3, as sampled at the last clock edge.
- R3: dev_irq[c] is high exactly when CPU c's masked request is nonzero. It follows a mask write or a raw request change one clock later.
- R4: A write to index 1 (miscellaneous) posts an IPI to each CPU c whose bit 12+c is set. ipi_irq[c] rises on the next clock.
- R5: In a miscellaneous write, bit 8+c clears CPU c's pending IPI and bit 4+c clears CPU c's pending timer interrupt. When the same write posts and clears one IPI, the clear wins.
- R6: Bit 28 of a miscellaneous write is an error acknowledge and changes no state.
- R7: Reading index 1 returns the pending IPIs in bits 11:8, the pending timers in bits 7:4 and bus_cpu_id in bits 1:0. All other bits read zero.
- R8: A timer_tick cycle makes every CPU's timer interrupt pending. The tick wins over a timer clear in the same cycle.
- R9: Index 14 reads the pending IPIs in bits 3:0 and clears them on a write by bitmask. Index 15 does the same for pending timers. A write to index 16 posts IPIs by bitmask in bits 3:0.
- R10: Index 0, indices 2 to 5, index 16 and every unmapped index read zero. Writes to indices with no function change nothing.
- R11: Posting an already pending IPI, or clearing an IPI or timer bit that is not pending, leaves that bit unchanged and sets err_flag. err_flag stays high until reset.
- R12: After reset all masks, masked requests and pending bits are zero, and every interrupt output and err_flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset from the block base |
| bus_we | input | 1 | Write strobe for one 64-bit write |
| bus_wdata | input | 64 | Write data |
| bus_cpu_id | input | 2 | Number of the CPU making the access |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| dev_req | input | 64 | Raw device request vector |
| timer_tick | input | 1 | Interval-timer tick, one cycle per tick |
| dev_irq | output | 4 | Device interrupt line per CPU |
| ipi_irq | output | 4 | IPI line per CPU |
| tmr_irq | output | 4 | Interval-timer line per CPU |
| err_flag | output | 1 | Sticky flag for redundant posts or empty clears |

## Verification
The bench goes after the cases where two causes meet in one cycle. These are a post and a clear of the same IPI in one write, and a tick together with a timer clear. A design that applied them in the wrong order would leave the IPI pending or drop the timer bit. It also changes the raw request input while the masks stay still, which catches a design that re-evaluates only on mask writes because its dev_irq would go stale. Register hits at nonzero offsets inside a 64-byte stride catch a decoder that uses the low address bits. Redundant posts and empty clears check that a design raises the flag and leaves no stray state change.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Register selector produced by the address decoder
    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_MISC,
        SEL_MASK,
        SEL_MREQ,
        SEL_IPI_PEND,
        SEL_TMR_PEND,
        SEL_IPI_POST
    } reg_sel_e;

    localparam int STRIDE_SHIFT = 6;
    localparam int IDX_MISC     = 1;
    localparam int MASK_BASE    = 6;

    // Field positions inside the miscellaneous register
    localparam int MISC_TMR_CLR_LSB = 4;
    localparam int MISC_IPI_CLR_LSB = 8;
    localparam int MISC_IPI_SET_LSB = 12;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_route_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]       addr,
    output reg_sel_e                sel,
    output logic [$clog2(NCPU)-1:0] cpu
);
    localparam int CPU_W        = $clog2(NCPU);
    localparam int IDX_W        = ADDR_W - STRIDE_SHIFT;
    localparam int MREQ_BASE    = MASK_BASE + NCPU;
    localparam int IPI_PEND_IDX = MREQ_BASE + NCPU;
    localparam int TMR_PEND_IDX = IPI_PEND_IDX + 1;
    localparam int IPI_POST_IDX = IPI_PEND_IDX + 2;

    logic [IDX_W-1:0] idx;
    int               idx_n;

    always_comb begin
        idx   = IDX_W'(addr >> STRIDE_SHIFT);
        idx_n = int'(idx);
        sel   = SEL_ZERO;
        cpu   = '0;
        if (idx_n == IDX_MISC) begin
            sel = SEL_MISC;
        end else if (idx_n >= MASK_BASE && idx_n < MREQ_BASE) begin
            sel = SEL_MASK;
            cpu = CPU_W'(idx_n - MASK_BASE);
        end else if (idx_n >= MREQ_BASE && idx_n < IPI_PEND_IDX) begin
            sel = SEL_MREQ;
            cpu = CPU_W'(idx_n - MREQ_BASE);
        end else if (idx_n == IPI_PEND_IDX) begin
            sel = SEL_IPI_PEND;
        end else if (idx_n == TMR_PEND_IDX) begin
            sel = SEL_TMR_PEND;
        end else if (idx_n == IPI_POST_IDX) begin
            sel = SEL_IPI_POST;
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int NCPU = 4,
    parameter int DW   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCPU-1:0]           wr_en,
    input  logic [DW-1:0]             wr_data,
    input  logic [DW-1:0]             raw_req,
    output logic [NCPU-1:0][DW-1:0]   mask_q,
    output logic [NCPU-1:0][DW-1:0]   masked_q,
    output logic [NCPU-1:0]           dev_irq
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [DW-1:0] mask_nx;

        always_comb begin
            mask_nx = wr_en[c] ? wr_data : mask_q[c];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[c]   <= '0;
                masked_q[c] <= '0;
            end else begin
                mask_q[c]   <= mask_nx;
                masked_q[c] <= mask_nx & raw_req;
            end
        end

        assign dev_irq[c] = |masked_q[c];

        // R2
        mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[c] |=> mask_q[c] == $past(wr_data));

        // R2
        mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[c] |=> $stable(mask_q[c]));

        // R3
        mreq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en[c] && $stable(raw_req)) |=> $stable(masked_q[c]));
    end

endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
    parameter int N        = 4,
    parameter bit SET_WINS = 1'b0,
    parameter bit FLAG_SET = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q,
    output logic         err_pulse
);
    logic [N-1:0] pend_nx;

    always_comb begin
        if (SET_WINS) pend_nx = (pend_q & ~clr_vec) | set_vec;
        else          pend_nx = (pend_q | set_vec) & ~clr_vec;
        err_pulse = (FLAG_SET && (|(set_vec & pend_q))) || (|(clr_vec & ~pend_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nx;
    end

    // R4
    set_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & ~clr_vec)) |=>
            ((pend_q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

    // R5
    clr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|set_vec) && !(|clr_vec)) |=> $stable(pend_q));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DW     = 64,
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DW-1:0]           bus_wdata,
    input  logic [$clog2(NCPU)-1:0] bus_cpu_id,
    output logic [DW-1:0]           bus_rdata,
    input  logic [DW-1:0]           dev_req,
    input  logic                    timer_tick,
    output logic [NCPU-1:0]         dev_irq,
    output logic [NCPU-1:0]         ipi_irq,
    output logic [NCPU-1:0]         tmr_irq,
    output logic                    err_flag
);
    localparam int CPU_W = $clog2(NCPU);

    reg_sel_e                  sel;
    logic [CPU_W-1:0]          sel_cpu;
    logic [NCPU-1:0]           mask_we;
    logic [NCPU-1:0]           ipi_set, ipi_clr, tmr_set, tmr_clr;
    logic [NCPU-1:0]           ipi_pend, tmr_pend;
    logic                      ipi_err, tmr_err;
    logic [NCPU-1:0][DW-1:0]   mask_q, masked_q;

    irq_reg_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .cpu  (sel_cpu)
    );

    // Write-side decode: one strobe vector per action
    always_comb begin
        mask_we = '0;
        ipi_set = '0;
        ipi_clr = '0;
        tmr_clr = '0;
        if (bus_we) begin
            unique case (sel)
                SEL_MISC: begin
                    ipi_set = bus_wdata[MISC_IPI_SET_LSB +: NCPU];
                    ipi_clr = bus_wdata[MISC_IPI_CLR_LSB +: NCPU];
                    tmr_clr = bus_wdata[MISC_TMR_CLR_LSB +: NCPU];
                end
                SEL_MASK:     mask_we[sel_cpu] = 1'b1;
                SEL_IPI_PEND: ipi_clr = bus_wdata[NCPU-1:0];
                SEL_TMR_PEND: tmr_clr = bus_wdata[NCPU-1:0];
                SEL_IPI_POST: ipi_set = bus_wdata[NCPU-1:0];
                default: ;
            endcase
        end
    end

    assign tmr_set = {NCPU{timer_tick}};

    irq_mask_bank #(.NCPU(NCPU), .DW(DW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mask_we),
        .wr_data  (bus_wdata),
        .raw_req  (dev_req),
        .mask_q   (mask_q),
        .masked_q (masked_q),
        .dev_irq  (dev_irq)
    );

    irq_pend_unit #(.N(NCPU), .SET_WINS(1'b0), .FLAG_SET(1'b1)) u_ipi (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (ipi_set),
        .clr_vec   (ipi_clr),
        .pend_q    (ipi_pend),
        .err_pulse (ipi_err)
    );

    irq_pend_unit #(.N(NCPU), .SET_WINS(1'b1), .FLAG_SET(1'b0)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (tmr_set),
        .clr_vec   (tmr_clr),
        .pend_q    (tmr_pend),
        .err_pulse (tmr_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= err_flag | ipi_err | tmr_err;
    end

    assign ipi_irq = ipi_pend;
    assign tmr_irq = tmr_pend;

    // Read-side mux
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_MISC: begin
                bus_rdata[MISC_IPI_CLR_LSB +: NCPU] = ipi_pend;
                bus_rdata[MISC_TMR_CLR_LSB +: NCPU] = tmr_pend;
                bus_rdata[CPU_W-1:0]                = bus_cpu_id;
            end
            SEL_MASK:     bus_rdata = mask_q[sel_cpu];
            SEL_MREQ:     bus_rdata = masked_q[sel_cpu];
            SEL_IPI_PEND: bus_rdata[NCPU-1:0] = ipi_pend;
            SEL_TMR_PEND: bus_rdata[NCPU-1:0] = tmr_pend;
            default: ;
        endcase
    end

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R8
    tick_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_tick |=> (&tmr_irq));

endmodule

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [1:0]  bus_cpu_id = '0;
    logic [63:0] bus_rdata;
    logic [63:0] dev_req = '0;
    logic        timer_tick = 1'b0;
    logic [3:0]  dev_irq, ipi_irq, tmr_irq;
    logic        err_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    irq_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_cpu_id(bus_cpu_id), .bus_rdata(bus_rdata),
        .dev_req(dev_req), .timer_tick(timer_tick), .dev_irq(dev_irq),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err_flag(err_flag)
    );

    // Behavioural reference model
    logic [63:0] m_mask [4];
    logic [63:0] m_mreq [4];
    logic [3:0]  m_ipi, m_tmr;
    logic        m_err;
    logic [3:0]  ps, pc, tc;
    int          widx;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_mask[i] = '0; m_mreq[i] = '0; end
            m_ipi = '0; m_tmr = '0; m_err = 1'b0;
        end else begin
            ps = '0; pc = '0; tc = '0;
            widx = int'(bus_addr) / 64;
            if (bus_we) begin
                if (widx == 1) begin
                    ps = bus_wdata[15:12]; pc = bus_wdata[11:8]; tc = bus_wdata[7:4];
                end else if (widx >= 6 && widx <= 9) m_mask[widx-6] = bus_wdata;
                else if (widx == 14) pc = bus_wdata[3:0];
                else if (widx == 15) tc = bus_wdata[3:0];
                else if (widx == 16) ps = bus_wdata[3:0];
            end
            for (int i = 0; i < 4; i++) begin
                if (ps[i] && m_ipi[i]) m_err = 1'b1;
                if (pc[i] && !m_ipi[i]) m_err = 1'b1;
                if (tc[i] && !m_tmr[i]) m_err = 1'b1;
            end
            m_ipi = (m_ipi | ps) & ~pc;
            m_tmr = timer_tick ? 4'hF : (m_tmr & ~tc);
            for (int i = 0; i < 4; i++) m_mreq[i] = m_mask[i] & dev_req;
        end
    end

    function automatic logic [63:0] mread(int idx, logic [1:0] cid);
        if (idx == 1) return {52'd0, m_ipi, m_tmr, 2'b00, cid};
        if (idx >= 6 && idx <= 9) return m_mask[idx-6];
        if (idx >= 10 && idx <= 13) return m_mreq[idx-10];
        if (idx == 14) return {60'd0, m_ipi};
        if (idx == 15) return {60'd0, m_tmr};
        return 64'd0;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison of all registered outputs
    always @(negedge clk) begin
        if (live) begin
            logic [3:0] exp_dev;
            for (int i = 0; i < 4; i++) exp_dev[i] = (m_mreq[i] != 0);
            check("R3 dev_irq", {60'd0, dev_irq}, {60'd0, exp_dev});
            check("R4 ipi_irq", {60'd0, ipi_irq}, {60'd0, m_ipi});
            check("R8 tmr_irq", {60'd0, tmr_irq}, {60'd0, m_tmr});
            check("R11 err_flag", {63'd0, err_flag}, {63'd0, m_err});
        end
    end

    task automatic wr(int idx, int off, logic [63:0] data, bit tick);
        @(negedge clk);
        bus_addr = 12'(idx * 64 + off);
        bus_wdata = data;
        bus_we = 1'b1;
        timer_tick = tick;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        timer_tick = 1'b0;
    endtask

    task automatic rd(string req, int idx, int off, logic [1:0] cid);
        @(negedge clk);
        bus_addr = 12'(idx * 64 + off);
        bus_cpu_id = cid;
        #1;
        check(req, bus_rdata, mread(idx, cid));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 outputs", {51'd0, dev_irq, ipi_irq, tmr_irq, err_flag}, 64'd0);
        rst_n = 1'b1;
        live = 1'b1;
        rd("R12 mask0", 6, 0, 2'd0);
        rd("R12 misc", 1, 0, 2'd0);

        dev_req = 64'hF0F0_0000_0000_00FF;
        wr(6, 0, 64'h0000_0000_0000_000F, 1'b0);     // R2 mask0
        rd("R2 mask0 readback", 6, 0, 2'd0);
        rd("R2 masked0", 10, 0, 2'd0);
        wr(7, 40, 64'hF000_0000_0000_0000, 1'b0);    // R1 offset inside stride
        rd("R1 mask1 via offset", 7, 63, 2'd0);
        rd("R1 masked1", 11, 8, 2'd0);
        wr(8, 0, 64'h0000_0000_0000_0100, 1'b0);     // R3 no overlap
        rd("R3 masked2 zero", 12, 0, 2'd0);
        dev_req = 64'h0000_0000_0000_01FF;            // R3 raw change only
        @(negedge clk);
        @(negedge clk);
        rd("R3 masked2 after raw change", 12, 0, 2'd0);
        check("R3 dev_irq after raw change", {60'd0, dev_irq}, 64'h5);
        wr(6, 0, 64'd0, 1'b0);                        // R3 drop line
        rd("R3 masked0 cleared", 10, 0, 2'd0);

        // R11 before any error
        check("R11 err low", {63'd0, err_flag}, 64'd0);
        wr(1, 0, 64'h0000_5000, 1'b0);                // R4 post cpu0,2
        rd("R9 ipi pend", 14, 0, 2'd0);
        rd("R7 misc read cpu2", 1, 0, 2'd2);
        check("R4 ipi lines", {60'd0, ipi_irq}, 64'h5);
        wr(1, 0, 64'h0000_1000, 1'b0);                // R11 redundant post
        @(negedge clk);
        check("R11 err set", {63'd0, err_flag}, 64'd1);
        check("R11 ipi unchanged", {60'd0, ipi_irq}, 64'h5);
        wr(1, 0, 64'h0000_2100, 1'b0);                // R5 post cpu1, clear cpu0
        rd("R5 ipi after post/clear", 14, 0, 2'd0);
        wr(1, 0, 64'h0000_8800, 1'b0);                // R5 clear wins same cpu
        @(negedge clk);
        check("R5 clear wins", {60'd0, ipi_irq}, 64'h6);

        wr(0, 0, 64'd0, 1'b1);                        // R8 tick
        rd("R8 timer pend", 15, 0, 2'd0);
        wr(1, 0, 64'h0000_0030, 1'b0);                // R5 timer clear 0,1
        rd("R5 timer after clear", 15, 0, 2'd0);
        wr(1, 0, 64'h0000_00C0, 1'b1);                // R8 tick wins over clear
        @(negedge clk);
        check("R8 tick wins", {60'd0, tmr_irq}, 64'hF);
        wr(1, 0, 64'h1000_0000, 1'b0);                // R6 ack bit only
        rd("R6 misc unchanged", 1, 0, 2'd1);

        wr(15, 0, 64'h3, 1'b0);                       // R9 timer clear reg
        rd("R9 timer reg", 15, 0, 2'd0);
        wr(14, 0, 64'h2, 1'b0);                       // R9 ipi clear reg
        rd("R9 ipi reg", 14, 0, 2'd0);
        wr(16, 0, 64'h9, 1'b0);                       // R9 ipi post reg
        rd("R9 ipi after post reg", 14, 0, 2'd0);

        rd("R10 ctrl zero", 0, 0, 2'd0);
        for (int a = 2; a <= 5; a++) rd("R10 arb zero", a, 0, 2'd0);
        rd("R10 post reg reads zero", 16, 0, 2'd0);
        wr(40, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);     // R10 unmapped write
        rd("R10 unmapped zero", 40, 0, 2'd0);
        rd("R10 misc intact", 1, 0, 2'd3);
        wr(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);      // R10 ctrl write
        for (int m = 6; m <= 13; m++) rd("R10 masks intact", m, 0, 2'd0);
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule